// File: doc/BRIEF.md
# Pixel Gamma Correction Pipeline

This block corrects streaming RGB pixels on their way to a panel. Each pixel carries three 10-bit channels. Every channel goes through the same three steps, always in this order. First a signed offset is added and the sum is clamped. Next the value is scaled by an unsigned fixed-point gain and clamped again. Last, the value may go through a 256-entry lookup table that belongs to that channel. The offset and the gain are shared by all three channels. The tables are separate.

The corrected value is reduced to 8 bits. Two output options follow:
- red and blue can be exchanged;
- the bit order of every channel can be reversed.

A valid flag travels with the data through a fixed four-stage pipeline. Outside valid pixels (during blanking) all data outputs are held at zero. A 6-bit panel connects to bits 7..2 of each output channel.

Software sets the block up through one write port. The port loads the offset, the gain, the option flags and the table contents.

Top module: `pix_gamma_top`

## Requirements
- R1: While rst_ni is low, and after it is released with no pixel input, pix_vld_o is 0 and r_o, g_o and b_o are 0.
- R2: After reset the settings are: offset 0, gain 1024 (unity), all flags clear. With these settings each output channel equals bits 9..2 of the matching input channel.
- R3: A pixel sampled with pix_vld_i high on a rising edge appears on the outputs, with pix_vld_o high, after the fourth rising edge from that one. pix_vld_o follows pix_vld_i delayed by exactly four cycles.
- R4: Stage one adds the shared 10-bit two's-complement offset (-512..+511) to each channel. A negative sum becomes 0 and a sum above 1023 becomes 1023.
- R5: Stage two multiplies the stage-one result by the shared 11-bit gain (1 integer bit, 10 fraction bits, 0..2047/1024). The product is shifted right by 10, dropping the fraction, and a result above 1023 becomes 1023.
- R6: With gamma enabled, bits 9..2 of the stage-two result index that channel's own 256 x 10-bit table. The channel's output is bits 9..2 of the table entry.
- R7: With gamma disabled, the output is bits 9..2 of the stage-two result, whatever the tables hold.
- R8: With red/blue swap set, r_o carries the corrected blue channel and b_o carries the corrected red channel. g_o is unaffected.
- R9: With bit reversal set, output bit k of every channel carries bit 7-k of the corrected 8-bit value.
- R10: Whenever pix_vld_o is 0, r_o, g_o and b_o are 0.
- R11: The write port decodes wr_addr_i[10:8] as the region and acts when wr_en_i is high:
  - Regions 0, 1 and 2 write wr_data_i[9:0] into the red, green or blue table entry wr_addr_i[7:0].
  - Region 3 writes a setting chosen by wr_addr_i[1:0]:
    - 0 sets the offset from wr_data_i[9:0];
    - 1 sets the gain from wr_data_i[10:0];
    - 2 sets the flags: bit 0 gamma enable, bit 1 red/blue swap, bit 2 bit reversal.
  - Region 3 with wr_addr_i[1:0]=3, and regions 4 to 7, change nothing.
  - Settings change only on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for settings and tables |
| wr_addr_i | input | 11 | Region [10:8], table entry or setting select [7:0] |
| wr_data_i | input | 11 | Write data |
| pix_vld_i | input | 1 | Input pixel valid |
| r_i | input | 10 | Red input channel |
| g_i | input | 10 | Green input channel |
| b_i | input | 10 | Blue input channel |
| pix_vld_o | output | 1 | Output pixel valid |
| r_o | output | 8 | Red output channel |
| g_o | output | 8 | Green output channel |
| b_o | output | 8 | Blue output channel |

## Verification
The pass-through and latency properties assume that the settings stay unchanged for more than four cycles around any pixel they judge. The checker enforces this by tracking how long the settings have been steady, and it judges only outside that window. The stimulus writes settings and tables only after the pipeline has drained: four blank cycles follow the last valid pixel. So no pixel in flight ever sees a mix of old and new settings. The stimulus also loads every table entry before it enables gamma, so no lookup reads an unwritten location.

// File: rtl/pix_gamma_pkg.sv
package pix_gamma_pkg;
  localparam int unsigned PIX_W    = 10;
  localparam int unsigned OUT_W    = 8;
  localparam int unsigned FRAC_W   = 10;
  localparam int unsigned GAIN_W   = FRAC_W + 1;
  localparam int unsigned LUT_AW   = 8;
  localparam int unsigned LUT_D    = 1 << LUT_AW;
  localparam int unsigned N_CH     = 3;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned WA_W     = SEL_W + LUT_AW;
  localparam int unsigned WD_W     = GAIN_W;
  localparam int unsigned PIPE_LAT = 4;
  localparam int unsigned PIX_MAX  = (1 << PIX_W) - 1;

  localparam logic [GAIN_W-1:0] GAIN_ONE  = GAIN_W'(1) << FRAC_W;
  localparam logic [SEL_W-1:0]  SEL_CTRL  = SEL_W'(3);
  localparam logic [1:0]        CTRL_OFF  = 2'd0;
  localparam logic [1:0]        CTRL_GAIN = 2'd1;
  localparam logic [1:0]        CTRL_FLAG = 2'd2;

  typedef struct packed {
    logic signed [PIX_W-1:0] offset;
    logic [GAIN_W-1:0]       gain;
    logic                    gamma_en;
    logic                    rb_swap;
    logic                    bit_rev;
  } cfg_t;
endpackage

// File: rtl/pix_gamma_cfg.sv
module pix_gamma_cfg
  import pix_gamma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WA_W-1:0]   wr_addr_i,
  input  logic [WD_W-1:0]   wr_data_i,
  output cfg_t              cfg_o,
  output logic [N_CH-1:0]   lut_we_o,
  output logic [LUT_AW-1:0] lut_addr_o,
  output logic [PIX_W-1:0]  lut_data_o
);
  logic [SEL_W-1:0] sel;
  logic             ctrl_we;
  cfg_t             cfg_q;

  assign sel        = wr_addr_i[WA_W-1 -: SEL_W];
  assign ctrl_we    = wr_en_i && (sel == SEL_CTRL);
  assign lut_addr_o = wr_addr_i[LUT_AW-1:0];
  assign lut_data_o = wr_data_i[PIX_W-1:0];
  assign cfg_o      = cfg_q;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_we
    assign lut_we_o[ch] = wr_en_i && (sel == SEL_W'(ch));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.offset   <= '0;
      cfg_q.gain     <= GAIN_ONE;
      cfg_q.gamma_en <= 1'b0;
      cfg_q.rb_swap  <= 1'b0;
      cfg_q.bit_rev  <= 1'b0;
    end else if (ctrl_we) begin
      unique case (wr_addr_i[1:0])
        CTRL_OFF:  cfg_q.offset <= $signed(wr_data_i[PIX_W-1:0]);
        CTRL_GAIN: cfg_q.gain   <= wr_data_i[GAIN_W-1:0];
        CTRL_FLAG: begin
          cfg_q.gamma_en <= wr_data_i[0];
          cfg_q.rb_swap  <= wr_data_i[1];
          cfg_q.bit_rev  <= wr_data_i[2];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pix_gamma_arith.sv
module pix_gamma_arith
  import pix_gamma_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [PIX_W-1:0]        din_i,
  input  logic signed [PIX_W-1:0] offset_i,
  input  logic [GAIN_W-1:0]       gain_i,
  output logic [PIX_W-1:0]        dout_o
);
  localparam int unsigned SUM_W  = PIX_W + 2;
  localparam int unsigned PROD_W = PIX_W + GAIN_W;

  logic signed [SUM_W-1:0] sum;
  logic [PIX_W-1:0]        ofs_q, ofs_d;
  logic [PROD_W-1:0]       prod;
  logic [PIX_W-1:0]        gain_d, gain_q;

  // stage 1: signed offset, clamp to 0..max
  always_comb begin
    sum = $signed({2'b00, din_i}) + $signed({{2{offset_i[PIX_W-1]}}, offset_i});
    if (sum < 0)                          ofs_d = '0;
    else if (sum > $signed(SUM_W'(PIX_MAX))) ofs_d = PIX_W'(PIX_MAX);
    else                                  ofs_d = sum[PIX_W-1:0];
  end

  // stage 2: fixed-point gain, floor, clamp
  always_comb begin
    prod = PROD_W'(ofs_q) * PROD_W'(gain_i);
    if (|prod[PROD_W-1:FRAC_W+PIX_W]) gain_d = PIX_W'(PIX_MAX);
    else                              gain_d = prod[FRAC_W +: PIX_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_q  <= '0;
      gain_q <= '0;
    end else begin
      ofs_q  <= ofs_d;
      gain_q <= gain_d;
    end
  end

  assign dout_o = gain_q;
endmodule

// File: rtl/pix_gamma_lut.sv
module pix_gamma_lut
  import pix_gamma_pkg::*;
(
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [LUT_AW-1:0] waddr_i,
  input  logic [PIX_W-1:0]  wdata_i,
  input  logic [LUT_AW-1:0] raddr_i,
  output logic [PIX_W-1:0]  rdata_o
);
  logic [PIX_W-1:0] mem [LUT_D];
  logic [PIX_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/pix_gamma_top.sv
module pix_gamma_top
  import pix_gamma_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WA_W-1:0]  wr_addr_i,
  input  logic [WD_W-1:0]  wr_data_i,
  input  logic             pix_vld_i,
  input  logic [PIX_W-1:0] r_i,
  input  logic [PIX_W-1:0] g_i,
  input  logic [PIX_W-1:0] b_i,
  output logic             pix_vld_o,
  output logic [OUT_W-1:0] r_o,
  output logic [OUT_W-1:0] g_o,
  output logic [OUT_W-1:0] b_o
);
  cfg_t              cfg;
  logic [N_CH-1:0]   lut_we;
  logic [LUT_AW-1:0] lut_waddr;
  logic [PIX_W-1:0]  lut_wdata;

  logic [PIX_W-1:0]  pix_in  [N_CH];
  logic [PIX_W-1:0]  corr    [N_CH];
  logic [PIX_W-1:0]  byp_q   [N_CH];
  logic [PIX_W-1:0]  lut_rd  [N_CH];
  logic [OUT_W-1:0]  sel8    [N_CH];
  logic [OUT_W-1:0]  out_d   [N_CH];
  logic [OUT_W-1:0]  out_q   [N_CH];
  logic [PIPE_LAT-1:0] vld_q;

  assign pix_in[0] = r_i;
  assign pix_in[1] = g_i;
  assign pix_in[2] = b_i;

  pix_gamma_cfg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg),
    .lut_we_o  (lut_we),
    .lut_addr_o(lut_waddr),
    .lut_data_o(lut_wdata)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    pix_gamma_arith u_arith (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .din_i   (pix_in[ch]),
      .offset_i(cfg.offset),
      .gain_i  (cfg.gain),
      .dout_o  (corr[ch])
    );

    pix_gamma_lut u_lut (
      .clk_i  (clk_i),
      .we_i   (lut_we[ch]),
      .waddr_i(lut_waddr),
      .wdata_i(lut_wdata),
      .raddr_i(corr[ch][PIX_W-1 -: LUT_AW]),
      .rdata_o(lut_rd[ch])
    );

    // bypass path aligned with the table read
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byp_q[ch] <= '0;
      else         byp_q[ch] <= corr[ch];
    end

    assign sel8[ch] = cfg.gamma_en ? lut_rd[ch][PIX_W-1 -: OUT_W]
                                   : byp_q[ch][PIX_W-1 -: OUT_W];

    always_comb begin
      logic [OUT_W-1:0] src;
      src = cfg.rb_swap ? sel8[N_CH-1-ch] : sel8[ch];
      for (int k = 0; k < OUT_W; k++)
        out_d[ch][k] = cfg.bit_rev ? src[OUT_W-1-k] : src[k];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         out_q[ch] <= '0;
      else if (vld_q[2])   out_q[ch] <= out_d[ch];
      else                 out_q[ch] <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[PIPE_LAT-2:0], pix_vld_i};
  end

  assign pix_vld_o = vld_q[PIPE_LAT-1];
  assign r_o       = out_q[0];
  assign g_o       = out_q[1];
  assign b_o       = out_q[2];
endmodule

// File: rtl/pix_gamma_chk.sv
module pix_gamma_chk
  import pix_gamma_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input cfg_t             cfg_i,
  input logic             pix_vld_i,
  input logic [PIX_W-1:0] r_i,
  input logic [PIX_W-1:0] g_i,
  input logic [PIX_W-1:0] b_i,
  input logic             pix_vld_o,
  input logic [OUT_W-1:0] r_o,
  input logic [OUT_W-1:0] g_o,
  input logic [OUT_W-1:0] b_o
);
  logic [2:0] age_q;
  logic [2:0] steady_q;
  cfg_t       cfg_prev_q;
  logic       plain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q      <= '0;
      steady_q   <= '0;
      cfg_prev_q <= '0;
    end else begin
      if (age_q < 3'd4) age_q <= age_q + 3'd1;
      cfg_prev_q <= cfg_i;
      if (cfg_i != cfg_prev_q) steady_q <= '0;
      else if (steady_q < 3'd5) steady_q <= steady_q + 3'd1;
    end
  end

  assign plain = (cfg_i.offset == '0) && (cfg_i.gain == GAIN_ONE) &&
                 !cfg_i.gamma_en && !cfg_i.rb_swap && !cfg_i.bit_rev;

  // R10
  blank_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_vld_o |-> (r_o == '0 && g_o == '0 && b_o == '0));

  // R3
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 3'd4) |-> (pix_vld_o == $past(pix_vld_i, 4)));

  // R2
  passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 3'd4 && steady_q == 3'd5 && plain && pix_vld_o) |->
      (r_o == $past(r_i[PIX_W-1 -: OUT_W], 4) &&
       g_o == $past(g_i[PIX_W-1 -: OUT_W], 4) &&
       b_o == $past(b_i[PIX_W-1 -: OUT_W], 4)));

  // R11
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 3'd0 && !$past(wr_en_i)) |-> $stable(cfg_i));
endmodule

bind pix_gamma_top pix_gamma_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .cfg_i    (cfg),
  .pix_vld_i(pix_vld_i),
  .r_i      (r_i),
  .g_i      (g_i),
  .b_i      (b_i),
  .pix_vld_o(pix_vld_o),
  .r_o      (r_o),
  .g_o      (g_o),
  .b_o      (b_o)
);

// File: tb/tb_pix_gamma_top.sv
module tb_pix_gamma_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [10:0] wr_addr_i = '0;
  logic [10:0] wr_data_i = '0;
  logic        pix_vld_i = 1'b0;
  logic [9:0]  r_i = '0, g_i = '0, b_i = '0;
  logic        pix_vld_o;
  logic [7:0]  r_o, g_o, b_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of the settings
  int   m_off = 0;
  int   m_gain = 1024;
  bit   m_gam = 0, m_swp = 0, m_rev = 0;
  logic [9:0] lut_m [3][256];

  // expectation history, [0] newest
  logic       h_v [4];
  logic [7:0] h_d [4][3];
  string      h_req [4];

  always #2 clk_i = ~clk_i;

  pix_gamma_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .pix_vld_i(pix_vld_i), .r_i(r_i), .g_i(g_i), .b_i(b_i),
    .pix_vld_o(pix_vld_o), .r_o(r_o), .g_o(g_o), .b_o(b_o)
  );

  function automatic int clamp10(int x);
    if (x < 0) return 0;
    if (x > 1023) return 1023;
    return x;
  endfunction

  function automatic logic [7:0] corr8(int x, int ch);
    int a, p;
    a = clamp10(x + m_off);
    p = clamp10((a * m_gain) >>> 10);
    if (m_gam) return lut_m[ch][p >> 2][9:2];
    return p[9:2];
  endfunction

  function automatic logic [7:0] rev8(logic [7:0] x);
    logic [7:0] y;
    for (int k = 0; k < 8; k++) y[k] = x[7-k];
    return y;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one pixel slot: check the output due now, then drive the next input
  task automatic step(bit v, int r, int g, int b, string req);
    logic [7:0] c [3];
    logic [7:0] e [3];
    chk(pix_vld_o == h_v[3], h_req[3], "vld", pix_vld_o, h_v[3]);
    chk(r_o == h_d[3][0] && g_o == h_d[3][1] && b_o == h_d[3][2], h_req[3], "rgb",
        {r_o, g_o, b_o}, {h_d[3][0], h_d[3][1], h_d[3][2]});
    c[0] = corr8(r, 0); c[1] = corr8(g, 1); c[2] = corr8(b, 2);
    for (int i = 0; i < 3; i++) begin
      e[i] = m_swp ? c[2-i] : c[i];
      if (m_rev) e[i] = rev8(e[i]);
      if (!v) e[i] = '0;
    end
    for (int i = 3; i > 0; i--) begin
      h_v[i] = h_v[i-1]; h_req[i] = h_req[i-1];
      for (int j = 0; j < 3; j++) h_d[i][j] = h_d[i-1][j];
    end
    h_v[0] = v; h_req[0] = req;
    for (int j = 0; j < 3; j++) h_d[0][j] = e[j];
    pix_vld_i = v; r_i = 10'(r); g_i = 10'(g); b_i = 10'(b);
    @(negedge clk_i);
  endtask

  task automatic flush();
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, "R10");
  endtask

  task automatic wr(int addr, int data);
    wr_en_i = 1'b1; wr_addr_i = 11'(addr); wr_data_i = 11'(data);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic set_off(int v);  wr(12'h300, v & 10'h3ff); m_off = v; endtask
  task automatic set_gain(int v); wr(12'h301, v); m_gain = v; endtask
  task automatic set_flags(bit gm, bit sw, bit rv);
    wr(12'h302, {sw ? 0 : 0} | (rv << 2) | (sw << 1) | gm);
    m_gam = gm; m_swp = sw; m_rev = rv;
  endtask

  task automatic t_reset();
    chk(pix_vld_o == 1'b0, "R1", "vld after reset", pix_vld_o, 0);
    chk(r_o == 0 && g_o == 0 && b_o == 0, "R1", "rgb after reset", {r_o, g_o, b_o}, 0);
  endtask

  task automatic t_default();
    step(1, 0, 1023, 513, "R2");
    step(1, 4, 7, 1020, "R2");
    step(0, 900, 900, 900, "R10");
    step(1, 256, 128, 64, "R3");
    step(0, 1, 2, 3, "R10");
    step(1, 1023, 0, 3, "R3");
    flush();
  endtask

  task automatic t_offset();
    set_off(100);
    step(1, 50, 1000, 0, "R4");
    step(1, 923, 924, 1023, "R4");
    flush();
    set_off(-512);
    step(1, 300, 1023, 511, "R4");
    step(1, 600, 512, 0, "R4");
    flush();
    set_off(511);
    step(1, 900, 0, 512, "R4");
    flush();
    set_off(0);
  endtask

  task automatic t_gain();
    set_gain(1536);
    step(1, 600, 800, 3, "R5");
    step(1, 682, 683, 1, "R5");
    flush();
    set_gain(0);
    step(1, 1023, 500, 7, "R5");
    flush();
    set_gain(512);
    step(1, 1023, 2, 3, "R5");
    flush();
    set_off(-200);
    set_gain(2047);
    step(1, 300, 711, 100, "R5");
    flush();
    set_off(0);
    set_gain(1024);
  endtask

  task automatic t_lut();
    for (int i = 0; i < 256; i++) begin
      lut_m[0][i] = 10'(1023 - 4 * i);
      lut_m[1][i] = 10'((i * i) >> 6);
      lut_m[2][i] = 10'(4 * i + 2);
      wr(12'h000 + i, lut_m[0][i]);
      wr(12'h100 + i, lut_m[1][i]);
      wr(12'h200 + i, lut_m[2][i]);
    end
    set_flags(1, 0, 0);
    step(1, 0, 0, 0, "R6");
    step(1, 1023, 1023, 1023, "R6");
    step(1, 512, 300, 77, "R6");
    step(1, 3, 803, 640, "R6");
    flush();
    set_off(40);
    set_gain(1300);
    step(1, 100, 500, 900, "R6");
    flush();
    set_off(0);
    set_gain(1024);
  endtask

  task automatic t_bypass();
    set_flags(0, 0, 0);
    step(1, 512, 300, 77, "R7");
    step(1, 3, 803, 640, "R7");
    flush();
  endtask

  task automatic t_ignore();
    set_flags(1, 0, 0);
    wr(12'h303, 11'h7ff);
    wr(12'h405, 11'h3ff);
    wr(12'h7ff, 11'h155);
    wr(12'h520, 11'h000);
    step(1, 20, 20, 20, "R11");
    step(1, 1023, 128, 512, "R11");
    flush();
  endtask

  task automatic t_swap();
    set_flags(0, 1, 0);
    step(1, 1023, 400, 8, "R8");
    step(1, 40, 41, 900, "R8");
    flush();
    set_flags(1, 1, 0);
    step(1, 0, 500, 1023, "R8");
    flush();
  endtask

  task automatic t_rev();
    set_flags(0, 0, 1);
    step(1, 4, 512, 1020, "R9");
    step(1, 100, 200, 300, "R9");
    flush();
    set_flags(1, 1, 1);
    step(1, 64, 600, 999, "R9");
    flush();
    set_flags(0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      h_v[i] = 0; h_req[i] = "R10";
      for (int j = 0; j < 3; j++) h_d[i][j] = '0;
    end
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_default();
    t_offset();
    t_gain();
    t_lut();
    t_bypass();
    t_ignore();
    t_swap();
    t_rev();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule